// File: doc/BRIEF.md
# Two-Stage Supervisory Watchdog

This block watches over a processor that must prove it is alive by pulsing a kick input at regular intervals. Once armed, a first countdown runs; every kick reloads it. If the kicks stop, the first countdown runs out. At that point the block raises the corrective actions that software has selected: a maskable interrupt, a non-maskable interrupt, and a latched fail-safe level that forces the controlled outputs into their safe state. In the same cycle it starts a second countdown.

The second countdown is a grace period. It gives the processor time to save state or debug data before the system is reset. A kick during the grace period counts as recovery: the block drops both interrupts and goes back to the first countdown. The fail-safe level stays on until software clears it. If the grace period runs out, the block issues a system reset, provided that action is selected. The reset is a pulse whose width is programmable, not a level. Once the pulse ends, the block goes back to an idle, disarmed state with every output low.

The first period, the grace period and the pulse width are each programmed through a 16-bit value, and a value of zero behaves as one cycle. A 4-bit mask selects the actions: bit 0 is the maskable interrupt, bit 1 the non-maskable interrupt, bit 2 fail-safe and bit 3 the reset.

Top module: `twostage_watchdog`

## Requirements
- R1: A rising edge on `enable` arms the block. While it is armed and in the first stage, a kick reloads the first countdown. No action fires until `stage1Period` cycles have passed without a kick.
- R2: If `stage1Period` (P1) cycles pass with no kick after arming or after the last kick, the selected interrupt outputs go high in the cycle that the grace countdown starts. That cycle is the P1-th clock edge after the edge that armed the block or took the last kick.
- R3: `failSafeOut` is set at first-stage expiry when mask bit 2 is 1. It stays high through kicks. It falls only when `failSafeClear` is sampled high or when a reset pulse ends. When a set and a clear fall in the same cycle, the set wins.
- R4: If no kick arrives and `enable` stays high, the grace countdown expires exactly `stage2Period` edges after first-stage expiry. Whatever else the processor is doing, the reset pulse then starts, when mask bit 3 is 1.
- R5: `sysResetOut` stays high for exactly `pulseWidth` cycles.
- R6: Each action appears only if its mask bit is 1: bit 0 drives `irqOut`, bit 1 drives `nmiOut`, bit 2 drives `failSafeOut` and bit 3 drives `sysResetOut`. If bit 3 is 0, grace expiry returns the block to idle without any pulse.
- R7: A kick during the grace period clears `irqOut` and `nmiOut` on the next edge and reloads the first countdown.
- R8: A period or width value of zero behaves as one cycle.
- R9: After reset, and after a reset pulse ends, all four outputs are low. The block stays idle until `enable` goes low and then high again.
- R10: The interrupt outputs are levels. They stay high for the whole grace period unless a kick, a disable or grace expiry clears them.
- R11: Driving `enable` low during the first stage or the grace period returns the block to idle and clears both interrupts. The fail-safe level is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Arms the block on a rising edge; low disarms it |
| kick | input | 1 | Service strobe from software |
| stage1Period | input | 16 | First countdown length in cycles |
| stage2Period | input | 16 | Grace countdown length in cycles |
| pulseWidth | input | 16 | Reset pulse width in cycles |
| actionMask | input | 4 | Action select: bit 0 irq, bit 1 nmi, bit 2 fail-safe, bit 3 reset |
| failSafeClear | input | 1 | Clears the latched fail-safe level |
| irqOut | output | 1 | Maskable interrupt level |
| nmiOut | output | 1 | Non-maskable interrupt level |
| failSafeOut | output | 1 | Forces controlled outputs to their safe state |
| sysResetOut | output | 1 | System reset pulse |

## Verification
Steady kicking at a rate faster than the first period shows that reloads work. Stopping the kicks shows that expiry lands on the exact edge, not one cycle early or late. A kick placed in the middle of the grace period separates recovery from a reset, and it shows that fail-safe is held while the interrupts fall. Masks with only some bits set, and zero-valued periods, show that each action is gated on its own bit and that zero is handled as one cycle. A disable during the grace period, and a steady high `enable` after a pulse, show that the block disarms and does not re-arm on its own.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ACT_IRQ = 0;
  localparam int ACT_NMI = 1;
  localparam int ACT_FS  = 2;
  localparam int ACT_RST = 3;
  localparam int NUM_ACT = 4;
  localparam int NUM_FLAG = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GRACE, ST_PULSE} wdtState_t;
  typedef enum logic [1:0] {LD_NONE, LD_STAGE1, LD_STAGE2, LD_WIDTH} loadSel_t;

  typedef struct packed {
    loadSel_t loadSel;
    logic     countDown;
    logic     clearCount;
    logic     raiseAct;
    logic     dropIrq;
    logic     dropFs;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  wdtStrobe_t          strobe,
  input  logic [CNT_W-1:0]    stage1Period,
  input  logic [CNT_W-1:0]    stage2Period,
  input  logic [CNT_W-1:0]    pulseWidth,
  input  logic [NUM_ACT-1:0]  actionMask,
  input  logic                failSafeClear,
  output logic                cntIsOne,
  output logic                irqOut,
  output logic                nmiOut,
  output logic                failSafeOut
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]    count;
  logic [CNT_W-1:0]    loadValue;
  logic [NUM_FLAG-1:0] actFlag;

  function automatic logic [CNT_W-1:0] atLeastOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  always_comb begin
    unique case (strobe.loadSel)
      LD_STAGE1: loadValue = atLeastOne(stage1Period);
      LD_STAGE2: loadValue = atLeastOne(stage2Period);
      LD_WIDTH:  loadValue = atLeastOne(pulseWidth);
      default:   loadValue = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.loadSel != LD_NONE) begin
      count <= loadValue;
    end else if (strobe.clearCount) begin
      count <= '0;
    end else if (strobe.countDown && count != '0) begin
      count <= count - ONE;
    end
  end

  assign cntIsOne = (count == ONE);

  generate
    for (genvar i = 0; i < NUM_FLAG; i++) begin : g_flag
      logic clrThis;
      if (i == ACT_FS) begin : g_fs
        assign clrThis = strobe.dropFs | failSafeClear;
      end else begin : g_int
        assign clrThis = strobe.dropIrq;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          actFlag[i] <= 1'b0;
        end else if (strobe.raiseAct && actionMask[i]) begin
          actFlag[i] <= 1'b1;
        end else if (clrThis) begin
          actFlag[i] <= 1'b0;
        end
      end
    end
  endgenerate

  assign irqOut      = actFlag[ACT_IRQ];
  assign nmiOut      = actFlag[ACT_NMI];
  assign failSafeOut = actFlag[ACT_FS];
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       kick,
  input  logic       cntIsOne,
  input  logic       resetSelected,
  output wdtStrobe_t strobe,
  output wdtState_t  state,
  output logic       pulseActive
);
  wdtState_t nextState;
  logic      enablePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      enablePrev <= 1'b0;
    end else begin
      state      <= nextState;
      enablePrev <= enable;
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (enable && !enablePrev) begin
          nextState      = ST_RUN;
          strobe.loadSel = LD_STAGE1;
        end
      end
      ST_RUN: begin
        if (!enable) begin
          nextState         = ST_IDLE;
          strobe.clearCount = 1'b1;
          strobe.dropIrq    = 1'b1;
        end else if (kick) begin
          strobe.loadSel = LD_STAGE1;
        end else if (cntIsOne) begin
          nextState       = ST_GRACE;
          strobe.loadSel  = LD_STAGE2;
          strobe.raiseAct = 1'b1;
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      ST_GRACE: begin
        if (!enable) begin
          nextState         = ST_IDLE;
          strobe.clearCount = 1'b1;
          strobe.dropIrq    = 1'b1;
        end else if (kick) begin
          nextState      = ST_RUN;
          strobe.loadSel = LD_STAGE1;
          strobe.dropIrq = 1'b1;
        end else if (cntIsOne) begin
          strobe.dropIrq = 1'b1;
          if (resetSelected) begin
            nextState      = ST_PULSE;
            strobe.loadSel = LD_WIDTH;
          end else begin
            nextState         = ST_IDLE;
            strobe.clearCount = 1'b1;
          end
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      ST_PULSE: begin
        if (cntIsOne) begin
          nextState         = ST_IDLE;
          strobe.clearCount = 1'b1;
          strobe.dropFs     = 1'b1;
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign pulseActive = (state == ST_PULSE);
endmodule

// File: rtl/twostage_watchdog.sv
module twostage_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               kick,
  input  logic [CNT_W-1:0]   stage1Period,
  input  logic [CNT_W-1:0]   stage2Period,
  input  logic [CNT_W-1:0]   pulseWidth,
  input  logic [NUM_ACT-1:0] actionMask,
  input  logic               failSafeClear,
  output logic               irqOut,
  output logic               nmiOut,
  output logic               failSafeOut,
  output logic               sysResetOut
);
  wdtStrobe_t strobe;
  wdtState_t  ctrlState;
  logic       cntIsOne;

  wdt_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .kick          (kick),
    .cntIsOne      (cntIsOne),
    .resetSelected (actionMask[ACT_RST]),
    .strobe        (strobe),
    .state         (ctrlState),
    .pulseActive   (sysResetOut)
  );

  wdt_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .stage1Period  (stage1Period),
    .stage2Period  (stage2Period),
    .pulseWidth    (pulseWidth),
    .actionMask    (actionMask),
    .failSafeClear (failSafeClear),
    .cntIsOne      (cntIsOne),
    .irqOut        (irqOut),
    .nmiOut        (nmiOut),
    .failSafeOut   (failSafeOut)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               kick,
  input logic [NUM_ACT-1:0] actionMask,
  input logic               failSafeClear,
  input wdtState_t          state,
  input logic               irqOut,
  input logic               nmiOut,
  input logic               failSafeOut,
  input logic               sysResetOut
);
  AST_KICK_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && kick && enable) |=> state == ST_RUN); // R1

  AST_NMI_AT_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiOut) |-> ($past(state) == ST_RUN && state == ST_GRACE)); // R2

  AST_FS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(failSafeOut) |-> ($past(failSafeClear) || $past(state) == ST_PULSE)); // R3

  AST_PULSE_AFTER_GRACE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysResetOut) |-> $past(state) == ST_GRACE); // R4

  AST_PULSE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysResetOut) |-> $past(actionMask[ACT_RST])); // R6

  AST_CLEAN_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_PULSE)
      |-> !(irqOut || nmiOut || failSafeOut || sysResetOut)); // R9

  AST_IRQ_IN_GRACE: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut || nmiOut) |-> state == ST_GRACE); // R10

  AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && state != ST_PULSE) |=> state == ST_IDLE); // R11
endmodule

bind twostage_watchdog wdt_checker chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .enable        (enable),
  .kick          (kick),
  .actionMask    (actionMask),
  .failSafeClear (failSafeClear),
  .state         (ctrlState),
  .irqOut        (irqOut),
  .nmiOut        (nmiOut),
  .failSafeOut   (failSafeOut),
  .sysResetOut   (sysResetOut)
);

// File: tb/twostage_watchdog_tb_top.sv
module twostage_watchdog_tb_top;
  logic        clk = 1'b0;
  logic        rstN, enable, kick, failSafeClear;
  logic [15:0] p1, p2, pw;
  logic [3:0]  mask;
  logic        irqOut, nmiOut, failSafeOut, sysResetOut;

  always #10 clk = ~clk;

  twostage_watchdog dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .kick(kick),
    .stage1Period(p1), .stage2Period(p2), .pulseWidth(pw),
    .actionMask(mask), .failSafeClear(failSafeClear),
    .irqOut(irqOut), .nmiOut(nmiOut), .failSafeOut(failSafeOut),
    .sysResetOut(sysResetOut)
  );

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  string tag = "R9";
  bit    done = 0;

  // Behavioural reference: 0 idle, 1 first stage, 2 grace, 3 pulse
  int mMode, mCnt;
  bit mIrq, mNmi, mFs, mEnPrev, setFs;

  function automatic int minOne(input logic [15:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mCnt = 0; mIrq = 0; mNmi = 0; mFs = 0; mEnPrev = 0;
    end else begin
      setFs = 0;
      if (mMode == 0) begin
        if (enable && !mEnPrev) begin mMode = 1; mCnt = minOne(p1); end
      end else if (mMode == 1) begin
        if (!enable) begin mMode = 0; mCnt = 0; mIrq = 0; mNmi = 0; end
        else if (kick) mCnt = minOne(p1);
        else if (mCnt == 1) begin
          mMode = 2; mCnt = minOne(p2);
          if (mask[0]) mIrq = 1;
          if (mask[1]) mNmi = 1;
          if (mask[2]) setFs = 1;
        end else mCnt--;
      end else if (mMode == 2) begin
        if (!enable) begin mMode = 0; mCnt = 0; mIrq = 0; mNmi = 0; end
        else if (kick) begin mMode = 1; mCnt = minOne(p1); mIrq = 0; mNmi = 0; end
        else if (mCnt == 1) begin
          mIrq = 0; mNmi = 0;
          if (mask[3]) begin mMode = 3; mCnt = minOne(pw); end
          else begin mMode = 0; mCnt = 0; end
        end else mCnt--;
      end else begin
        if (mCnt == 1) begin mMode = 0; mCnt = 0; mFs = 0; end
        else mCnt--;
      end
      if (setFs) mFs = 1;
      else if (failSafeClear) mFs = 0;
      mEnPrev = enable;
    end
    #2;
    total++;
    if (irqOut !== mIrq || nmiOut !== mNmi || failSafeOut !== mFs ||
        sysResetOut !== (mMode == 3)) begin
      bad++;
      $display("FAIL %s cycle %0d: actual irq=%b nmi=%b fs=%b rst=%b expected irq=%b nmi=%b fs=%b rst=%b",
               tag, cyc, irqOut, nmiOut, failSafeOut, sysResetOut,
               mIrq, mNmi, mFs, (mMode == 3));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      bad++;
      $display("FAIL %s watchdog expired: actual=hung expected=finished", tag);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string name, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", name, act, exp);
    end
  endtask

  initial begin
    int g, w;
    rstN = 0; enable = 0; kick = 0; failSafeClear = 0;
    p1 = 5; p2 = 6; pw = 3; mask = 4'hF;
    step(3);
    chk("R9 reset irq", irqOut, 0);
    chk("R9 reset nmi", nmiOut, 0);
    chk("R9 reset fs", failSafeOut, 0);
    chk("R9 reset rst", sysResetOut, 0);
    rstN = 1;
    step(1);

    tag = "R1";
    enable = 1;
    for (int i = 0; i < 6; i++) begin
      step(3); kick = 1; step(1); kick = 0;
    end
    chk("R1 no expiry while kicked", nmiOut, 0);

    tag = "R2";
    step(4);
    chk("R2 nmi one edge before expiry", nmiOut, 0);
    step(1);
    chk("R2 nmi at expiry", nmiOut, 1);
    chk("R6 irq at expiry", irqOut, 1);
    chk("R3 fs at expiry", failSafeOut, 1);

    tag = "R10";
    step(3);
    chk("R10 nmi level held in grace", nmiOut, 1);

    tag = "R7";
    kick = 1; step(1); kick = 0;
    chk("R7 nmi cleared by kick", nmiOut, 0);
    chk("R7 irq cleared by kick", irqOut, 0);
    chk("R3 fs kept over kick", failSafeOut, 1);

    tag = "R3";
    step(2);
    failSafeClear = 1; step(1); failSafeClear = 0;
    chk("R3 fs cleared", failSafeOut, 0);

    tag = "R4";
    g = 0;
    while (!nmiOut && g < 50) begin step(1); g++; end
    g = 0;
    while (!sysResetOut && g < 50) begin step(1); g++; end
    chk("R4 grace length", g, 6);
    tag = "R5";
    w = 0;
    while (sysResetOut && w < 50) begin step(1); w++; end
    chk("R5 pulse width", w, 3);
    tag = "R9";
    chk("R9 fs low after pulse", failSafeOut, 0);
    step(12);
    chk("R9 no re-arm with enable held", nmiOut, 0);
    chk("R9 no re-arm reset", sysResetOut, 0);

    tag = "R6";
    enable = 0; step(1);
    mask = 4'b0001; p1 = 2; p2 = 2;
    enable = 1;
    step(3);
    chk("R6 irq selected", irqOut, 1);
    chk("R6 nmi masked", nmiOut, 0);
    chk("R6 fs masked", failSafeOut, 0);
    step(2);
    chk("R6 irq dropped at grace end", irqOut, 0);
    chk("R6 no reset when masked", sysResetOut, 0);
    step(4);

    tag = "R8";
    enable = 0; step(1);
    mask = 4'hF; p1 = 0; p2 = 0; pw = 0;
    enable = 1;
    step(2);
    chk("R8 zero stage1 expires in one cycle", nmiOut, 1);
    step(1);
    chk("R8 zero grace then pulse", sysResetOut, 1);
    step(1);
    chk("R8 zero width one-cycle pulse", sysResetOut, 0);

    tag = "R11";
    enable = 0; step(1);
    p1 = 3; p2 = 10; pw = 2;
    enable = 1;
    step(4);
    chk("R11 grace reached", nmiOut, 1);
    enable = 0; step(1);
    chk("R11 nmi cleared by disable", nmiOut, 0);
    chk("R11 fs kept by disable", failSafeOut, 1);
    failSafeClear = 1; step(1); failSafeClear = 0;
    step(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule